// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block translates console bus addresses into upper ROM address lines for a game cartridge. The CPU programs eight internal bank registers indirectly. It first writes a register index to the even control address, then writes the bank number to the odd control address. The mapper uses those registers to build the upper PRG ROM lines for the CPU window $8000–$FFFF and the upper CHR ROM lines for the PPU pattern space $0000–$1FFF.

The CPU decode is masked. Only CPU A15, A14, A13 and A0 are examined, so every even address in $8000–$9FFF acts as the index port and every odd address there acts as the data port. The PRG map has two switchable 8K windows at $8000 and $A000; $C000 and $E000 are pinned to the last two banks. The lower pattern table holds two 2K banks and the upper pattern table holds four 1K banks.

A build-time parameter chooses the board wiring:
- `VARIANT` 0 is the plain board, with nametable A10 taken from a mirroring strap.
- `VARIANT` 1 routes PPU A12 to CHR bit 16, giving 128K of CHR.
- `VARIANT` 2 drives nametable A10 from bit 5 of the CHR bank selected by the PPU address.

Register writes land on the rising clock edge. All address outputs are combinational.

Top module: `bank_mapper`

## Requirements
- R1: After reset, every bank register and the index register hold zero. The $8000 and $A000 windows then output PRG bank 0, and every CHR page outputs bank 0.
- R2: A write with `romSelN` low, `cpuWe` high, cpuAddr[14:13]=00 and cpuAddr[0]=0 stores cpuData[2:0] as the register index. cpuData[7:3] is ignored.
- R3: A write with cpuAddr[14:13]=00 and cpuAddr[0]=1 stores cpuData[5:0] into the indexed register, and cpuData[7:6] is ignored. Registers 6 and 7 keep only cpuData[3:0].
- R4: The decode ignores cpuAddr[12:1], so $9FFE acts as the index port and $9FFF acts as the data port.
- R5: Writes with cpuAddr[14:13] not equal to 00 (CPU $A000–$FFFF) change no register.
- R6: Writes with `romSelN` high (CPU $0000–$7FFF) change no register.
- R7: For PPU addresses with A12=0, the CHR bank is register 0 (A11=0) or register 1 (A11=1). Bit 0 of the register is replaced by PPU A10.
- R8: For PPU addresses with A12=1, the CHR bank is register 2+ppuAddr[11:10].
- R9: `prgAddrHi` is register 6 for cpuAddr[14:13]=00 and register 7 for 01. It is 4'hE for 10 and 4'hF for 11.
- R10: With VARIANT=1, chrAddrHi[6] equals PPU A12. With the other variants it is 0.
- R11: With VARIANT 0 or 1, `ntA10` equals ppuAddr[10] when `mirrorVert` is 1 and ppuAddr[11] when it is 0.
- R12: With VARIANT=2, `ntA10` equals bit 5 of the CHR bank that the PPU address selects under R7/R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes land on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 15 | CPU A14..A0 |
| cpuData | input | 8 | CPU write data |
| cpuWe | input | 1 | CPU write strobe, active high |
| romSelN | input | 1 | Active-low ROM select (CPU A15 high) |
| ppuAddr | input | 14 | PPU A13..A0 |
| mirrorVert | input | 1 | Mirroring strap: 1 vertical, 0 horizontal |
| prgAddrHi | output | 4 | PRG ROM A16..A13 |
| chrAddrHi | output | 7 | CHR ROM A16..A10 |
| ntA10 | output | 1 | Nametable RAM A10 select |

## Verification
Every CHR register is loaded with all 64 values, and each load is checked against all eight 1K PPU pages. This separates a wrong register choice per page from a lost A10 pass-through in the 2K banks. Both PRG registers are swept the same way across all four CPU windows, which exposes width truncation and the pinned top banks. Index bytes carry junk in their upper bits, and data bytes carry junk above bit 5, so that dropping or keeping those bits gives different outputs. Writes at aliased, high-window and non-ROM addresses are followed by a full readout through the address outputs, and the three board variants run in parallel so the A12 and nametable wiring are compared on identical traffic.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int CPU_DW = 8;

  typedef struct packed {
    logic              selWr;
    logic              dataWr;
    logic [CPU_DW-1:0] data;
  } mapStrobes_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import bank_mapper_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [CPU_DW-1:0] cpuData,
  input  logic              cpuWe,
  input  logic              romSelN,
  output mapStrobes_t       strb
);
  logic ctrlHit;

  // Masked decode: only A14, A13 and A0 matter inside the ROM window.
  assign ctrlHit     = cpuWe && !romSelN && (cpuAddr[ADDR_W-1 -: 2] == 2'b00);
  assign strb.selWr  = ctrlHit && !cpuAddr[0];
  assign strb.dataWr = ctrlHit &&  cpuAddr[0];
  assign strb.data   = cpuData;

  p_high_window_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1 -: 2] != 2'b00) |-> !(strb.selWr || strb.dataWr));

  p_no_rom_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    romSelN |-> !(strb.selWr || strb.dataWr));

  p_single_port_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.selWr && strb.dataWr));
endmodule

// File: rtl/mapper_banks.sv
module mapper_banks
  import bank_mapper_pkg::*;
#(
  parameter int PRG_BITS = 4,
  parameter int CHR_BITS = 6,
  parameter int VARIANT  = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  mapStrobes_t         strb,
  input  logic [1:0]          cpuWin,
  input  logic [13:0]         ppuAddr,
  input  logic                mirrorVert,
  output logic [PRG_BITS-1:0] prgHi,
  output logic [CHR_BITS:0]   chrHi,
  output logic                ntA10
);
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int PAD_W    = CHR_BITS - PRG_BITS;

  logic [CHR_BITS-1:0] bankReg [NUM_REGS];
  logic [IDX_W-1:0]    bankIdx;
  logic [CHR_BITS-1:0] chrBank;
  logic [IDX_W-1:0]    hiPage;
  logic                isPrgIdx;

  assign isPrgIdx = (bankIdx[2:1] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankIdx <= '0;
      for (int i = 0; i < NUM_REGS; i++) bankReg[i] <= '0;
    end else begin
      if (strb.selWr) bankIdx <= strb.data[IDX_W-1:0];
      if (strb.dataWr) begin
        if (isPrgIdx) bankReg[bankIdx] <= {{PAD_W{1'b0}}, strb.data[PRG_BITS-1:0]};
        else          bankReg[bankIdx] <= strb.data[CHR_BITS-1:0];
      end
    end
  end

  // PRG: two switchable windows, then the last two banks pinned.
  always_comb begin
    case (cpuWin)
      2'b00:   prgHi = bankReg[6][PRG_BITS-1:0];
      2'b01:   prgHi = bankReg[7][PRG_BITS-1:0];
      2'b10:   prgHi = {{(PRG_BITS-1){1'b1}}, 1'b0};
      default: prgHi = '1;
    endcase
  end

  // CHR: 2K pairs in the lower table, 1K singles in the upper table.
  assign hiPage = {1'b0, ppuAddr[11:10]} + 3'd2;

  always_comb begin
    if (!ppuAddr[12]) chrBank = {bankReg[{2'b00, ppuAddr[11]}][CHR_BITS-1:1], ppuAddr[10]};
    else              chrBank = bankReg[hiPage];
  end

  generate
    if (VARIANT == 1) begin : g_split
      assign chrHi = {ppuAddr[12], chrBank};
      assign ntA10 = mirrorVert ? ppuAddr[10] : ppuAddr[11];
    end else if (VARIANT == 2) begin : g_ntsel
      assign chrHi = {1'b0, chrBank};
      assign ntA10 = chrBank[CHR_BITS-1];
    end else begin : g_plain
      assign chrHi = {1'b0, chrBank};
      assign ntA10 = mirrorVert ? ppuAddr[10] : ppuAddr[11];
    end
  endgenerate

  p_index_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.selWr |=> (bankIdx == $past(strb.data[IDX_W-1:0])));

  p_prg_narrow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bankReg[6][CHR_BITS-1:PRG_BITS] == '0) && (bankReg[7][CHR_BITS-1:PRG_BITS] == '0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.selWr || strb.dataWr) |=> ($stable(bankIdx) && $stable(bankReg[6]) && $stable(bankReg[0])));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int PRG_BITS = 4,
  parameter int CHR_BITS = 6,
  parameter int VARIANT  = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [14:0]         cpuAddr,
  input  logic [7:0]          cpuData,
  input  logic                cpuWe,
  input  logic                romSelN,
  input  logic [13:0]         ppuAddr,
  input  logic                mirrorVert,
  output logic [PRG_BITS-1:0] prgAddrHi,
  output logic [CHR_BITS:0]   chrAddrHi,
  output logic                ntA10
);
  mapStrobes_t strb;

  mapper_ctrl #(.ADDR_W(15)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWe(cpuWe), .romSelN(romSelN), .strb(strb)
  );

  mapper_banks #(.PRG_BITS(PRG_BITS), .CHR_BITS(CHR_BITS), .VARIANT(VARIANT)) banks_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWin(cpuAddr[14:13]),
    .ppuAddr(ppuAddr), .mirrorVert(mirrorVert),
    .prgHi(prgAddrHi), .chrHi(chrAddrHi), .ntA10(ntA10)
  );

  p_top_bank_fixed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[14:13] == 2'b11) |-> (prgAddrHi == '1));
endmodule

// File: tb/bank_mapper_tb_top.sv
`timescale 1ns/1ps
module bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWe = 1'b0;
  logic        romSelN = 1'b1;
  logic [13:0] ppuAddr = '0;
  logic        mirrorVert = 1'b0;

  logic [3:0] prg0, prg1, prg2;
  logic [6:0] chr0, chr1, chr2;
  logic       nt0, nt1, nt2;

  int checks = 0;
  int errors = 0;
  logic [5:0] model [8];

  always #2.5 clk = ~clk;

  bank_mapper #(.VARIANT(0)) dut_i (.clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWe(cpuWe), .romSelN(romSelN), .ppuAddr(ppuAddr), .mirrorVert(mirrorVert),
    .prgAddrHi(prg0), .chrAddrHi(chr0), .ntA10(nt0));
  bank_mapper #(.VARIANT(1)) dutSplit_i (.clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWe(cpuWe), .romSelN(romSelN), .ppuAddr(ppuAddr), .mirrorVert(mirrorVert),
    .prgAddrHi(prg1), .chrAddrHi(chr1), .ntA10(nt1));
  bank_mapper #(.VARIANT(2)) dutNt_i (.clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWe(cpuWe), .romSelN(romSelN), .ppuAddr(ppuAddr), .mirrorVert(mirrorVert),
    .prgAddrHi(prg2), .chrAddrHi(chr2), .ntA10(nt2));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a[14:0]; romSelN = !a[15]; cpuData = d; cpuWe = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0; romSelN = 1'b1;
    #1;
  endtask

  function automatic logic [5:0] expBank(logic [13:0] pa);
    if (!pa[12]) return {model[{2'b00, pa[11]}][5:1], pa[10]};
    return model[3'(pa[11:10]) + 3'd2];
  endfunction

  task automatic checkAllChr(string req);
    for (int pg = 0; pg < 8; pg++) begin
      logic [5:0] eb;
      ppuAddr = 14'(pg * 1024 + 16'h155);
      #1;
      eb = expBank(ppuAddr);
      check(req, chr0, {1'b0, eb});                    // R7 / R8
      check({req, "/R10"}, chr1, {ppuAddr[12], eb});   // R10
      check({req, "/R12"}, nt2, eb[5]);                // R12
    end
  endtask

  task automatic checkAllPrg(string req);
    for (int w = 0; w < 4; w++) begin
      int ep;
      cpuAddr = 15'(w * 16'h2000 + 16'h0123);
      #1;
      ep = (w == 0) ? model[6] : (w == 1) ? model[7] : (w == 2) ? 14 : 15;
      check(req, prg0, ep);
      check(req, prg2, ep);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: everything at zero after reset
    checkAllPrg("R1");
    checkAllChr("R1");

    // R2 R3 R7 R8: exhaustive CHR register sweep, junk in unused bits
    for (int r = 0; r < 6; r++) begin
      for (int v = 0; v < 64; v++) begin
        busWrite(16'h8000, {5'(v ^ 5'h15), 3'(r)});
        busWrite(16'h8001, {2'(v), 6'(v)});
        model[r] = 6'(v);
        checkAllChr("R3/R7/R8");
      end
    end

    // R3 R9: PRG registers keep 4 bits, top windows pinned
    for (int r = 6; r < 8; r++) begin
      for (int v = 0; v < 64; v++) begin
        busWrite(16'h8000, {5'h1F, 3'(r)});
        busWrite(16'h8001, {2'b10, 6'(v)});
        model[r] = 6'(v & 15);
        checkAllPrg("R3/R9");
      end
    end

    // R4: aliased control addresses
    busWrite(16'h9FFE, 8'h02);
    busWrite(16'h9FFF, 8'h2D);
    model[2] = 6'h2D;
    checkAllChr("R4");
    busWrite(16'h9ABC, 8'h07);
    busWrite(16'h8F31, 8'h09);
    model[7] = 6'h09;
    checkAllPrg("R4");

    // R5: high window writes ignored; index stays at 7
    busWrite(16'hA000, 8'h00);
    busWrite(16'hA001, 8'h3F);
    busWrite(16'hC001, 8'h21);
    busWrite(16'hE000, 8'h03);
    busWrite(16'hFFFF, 8'h11);
    checkAllPrg("R5");
    checkAllChr("R5");
    busWrite(16'h8001, 8'h05);
    model[7] = 6'h05;
    checkAllPrg("R5 index kept");

    // R6: writes with ROM select inactive are ignored
    busWrite(16'h0000, 8'h06);
    busWrite(16'h0001, 8'h0C);
    busWrite(16'h6001, 8'h3F);
    checkAllPrg("R6");
    checkAllChr("R6");
    busWrite(16'h8001, 8'h0A);
    model[7] = 6'h0A;
    checkAllPrg("R6 index kept");

    // R11: strap mirroring on variants 0 and 1
    for (int m = 0; m < 2; m++) begin
      for (int q = 0; q < 4; q++) begin
        mirrorVert = 1'(m);
        ppuAddr = 14'(16'h2000 + q * 16'h0400 + 16'h0011);
        #1;
        check("R11", nt0, m ? ppuAddr[10] : ppuAddr[11]);
        check("R11", nt1, m ? ppuAddr[10] : ppuAddr[11]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule